// File: doc/BRIEF.md
# Masked Breakpoint Unit with Delayed Trace Freeze

This block watches two address streams of a processor core: the addresses placed on the internal bus and the addresses of instructions as they execute. It holds a parameterised number of breakpoints, two by default. Each has its own compare address, compare mask, enable bit and stream selector. A breakpoint hits when its selected stream presents a valid address that agrees with the compare address on every bit whose mask bit is set.

A hit starts a freeze of the trace buffer. The freeze can be postponed by a programmable number of further stored trace entries. The trace logic reports each stored entry with a one-cycle pulse, and each pulse counts the delay down. When the freeze takes effect, the block can also raise a debug-mode request to the core. The freeze stays in place until software clears it. Per-breakpoint sticky hit flags show which breakpoint fired.

Software programs the block through a flat write port. The port carries a field code, a breakpoint index and a data word. Decoding a full register space is left to the surrounding logic.

Top module: `bkpt_freeze_unit`

## Requirements
- R1: After reset, trace_freeze, debug_req and every hit_status bit are 0. Every breakpoint is disabled, so no valid access can cause a freeze until software enables a breakpoint.
- R2: An enabled breakpoint hits when its selected stream is valid and ((addr XOR compare) AND mask) is zero. Address bits whose mask bit is 0 are ignored. An all-zero mask therefore matches every valid access of the selected stream.
- R3: Control bit 1 selects the stream: 0 selects the bus (bus_addr/bus_valid), 1 selects executed instructions (insn_addr/insn_valid). Accesses on the stream that is not selected never hit.
- R4: Control bit 0 enables the breakpoint. A breakpoint whose enable bit is 0 never hits.
- R5: The breakpoints are independent. hit_status[i] rises in the cycle after breakpoint i hits and stays high until a clear.
- R6: With a delay count of 0, trace_freeze rises combinationally in the same cycle as the hit.
- R7: With a delay count of N>0, trace_freeze rises during the cycle that carries the N-th trace_stored pulse after the hit cycle. A pulse in the hit cycle itself is not counted.
- R8: Hits that arrive while a delayed freeze is pending neither restart nor reload the countdown.
- R9: Once raised, trace_freeze stays high until a clear write. From the cycle after the clear write, the freeze, any pending countdown and all hit_status bits are 0. A hit in the same cycle as the clear write is dropped.
- R10: debug_req is high exactly while trace_freeze is high and the break-on-freeze bit is set.
- R11: wr_field codes: 0 compare address, 1 mask, 2 control (these three are selected by wr_bp), 3 global. In a global write, bits [CNT_W-1:0] hold the delay count, bit CNT_W holds break-on-freeze, and bit CNT_W+1 is a clear command. Written values are used from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Internal bus address |
| bus_valid | input | 1 | bus_addr carries a transfer this cycle |
| insn_addr | input | ADDR_W | Address of the executed instruction |
| insn_valid | input | 1 | insn_addr carries an executed instruction this cycle |
| trace_stored | input | 1 | One-cycle pulse per stored trace entry |
| wr_en | input | 1 | Register write strobe |
| wr_field | input | 2 | Field code (0 address, 1 mask, 2 control, 3 global) |
| wr_bp | input | IDX_W | Breakpoint index for field codes 0 to 2 |
| wr_data | input | ADDR_W | Write data |
| trace_freeze | output | 1 | Freeze command to the trace buffer |
| debug_req | output | 1 | Debug-mode request to the core |
| hit_status | output | NUM_BP | Sticky per-breakpoint hit flags |

## Verification
An exhaustive sweep of an 8-bit address space under several masks, including the all-zero mask, catches a comparator that inverts the mask sense or ignores it. Such a comparator would freeze on addresses that differ in compared bits, or fail to match everywhere.

The countdown is driven with a trace pulse in the hit cycle, a gap cycle and a second hit mid-countdown. A design that counts the hit-cycle pulse would freeze one entry early. A design that reloads on the second hit would freeze one entry late.

A clear coinciding with a hit checks the priority between the two. A write coinciding with a matching access checks that new register values take effect only from the next cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    // Write field codes on the flat register port
    typedef enum logic [1:0] {
        FLD_ADDR   = 2'd0,
        FLD_MASK   = 2'd1,
        FLD_CTRL   = 2'd2,
        FLD_GLOBAL = 2'd3
    } wr_field_e;

    // Bit positions inside a per-breakpoint control write
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SRC_BIT = 1;

endpackage

// File: rtl/bkpt_comparator.sv
module bkpt_comparator #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] insn_addr,
    input  logic              insn_valid,
    input  logic              we_addr,
    input  logic              we_mask,
    input  logic              we_ctrl,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              clr,
    output logic              hit,
    output logic              status
);
    import bkpt_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] cmp;
        logic [ADDR_W-1:0] mask;
        logic              en;
        logic              src_insn;
        logic              sticky;
    } cmp_state_t;

    cmp_state_t state_d, state_q;

    logic [ADDR_W-1:0] sel_addr;
    logic              sel_valid;
    logic [ADDR_W-1:0] diff_bits;

    always_comb begin
        sel_addr  = state_q.src_insn ? insn_addr  : bus_addr;
        sel_valid = state_q.src_insn ? insn_valid : bus_valid;
        diff_bits = (sel_addr ^ state_q.cmp) & state_q.mask;
        hit       = state_q.en && sel_valid && (diff_bits == '0);
    end

    always_comb begin
        state_d = state_q;
        if (we_addr) state_d.cmp  = wr_data;
        if (we_mask) state_d.mask = wr_data;
        if (we_ctrl) begin
            state_d.en       = wr_data[CTRL_EN_BIT];
            state_d.src_insn = wr_data[CTRL_SRC_BIT];
        end
        if (clr) state_d.sticky = 1'b0;
        else     state_d.sticky = state_q.sticky | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign status = state_q.sticky;

    // R5: a hit without a clear leaves the sticky flag set
    p_hit_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !clr |=> status);

    // R5: the flag holds until a clear
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status && !clr |=> status);

    // R9: a clear wipes the flag
    p_clear_wipes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !status);

    // R3: a breakpoint on the instruction stream never hits on bus-only traffic
    p_stream_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.src_insn && !insn_valid |-> !hit);

endmodule

// File: rtl/freeze_sequencer.sv
module freeze_sequencer #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_hit,
    input  logic              trace_stored,
    input  logic              we_global,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clr,
    output logic              trace_freeze,
    output logic              debug_req
);
    localparam int BOF_BIT = CNT_W;
    localparam int CLR_BIT = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] dly;
        logic             bof;
        logic             frozen;
        logic             pending;
        logic [CNT_W-1:0] count;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    logic start;
    logic fire_now;
    logic count_done;

    always_comb begin
        clr        = we_global && wr_data[CLR_BIT];
        start      = any_hit && !seq_q.frozen && !seq_q.pending && !clr;
        fire_now   = start && (seq_q.dly == '0);
        count_done = seq_q.pending && trace_stored && (seq_q.count == CNT_ONE) && !clr;

        trace_freeze = seq_q.frozen || fire_now || count_done;
        debug_req    = trace_freeze && seq_q.bof;

        seq_d = seq_q;
        if (we_global) begin
            seq_d.dly = wr_data[CNT_W-1:0];
            seq_d.bof = wr_data[BOF_BIT];
        end
        if (clr) begin
            seq_d.frozen  = 1'b0;
            seq_d.pending = 1'b0;
            seq_d.count   = '0;
        end else if (fire_now || count_done) begin
            seq_d.frozen  = 1'b1;
            seq_d.pending = 1'b0;
            seq_d.count   = '0;
        end else if (start) begin
            seq_d.pending = 1'b1;
            seq_d.count   = seq_q.dly;
        end else if (seq_q.pending && trace_stored) begin
            seq_d.count = seq_q.count - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R9: freeze persists until cleared
    p_freeze_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trace_freeze && !clr |=> trace_freeze);

    // R9: a clear drops freeze and countdown
    p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !seq_q.frozen && !seq_q.pending);

    // R7: a pending countdown never sits at zero
    p_count_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pending |-> seq_q.count != '0);

    // R8: without a trace pulse the countdown is not touched by new hits
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.pending && !trace_stored && !clr |=> $stable(seq_q.count));

    // R7: frozen and pending are exclusive
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_q.frozen && seq_q.pending));

endmodule

// File: rtl/bkpt_freeze_unit.sv
module bkpt_freeze_unit #(
    parameter int ADDR_W = 32,
    parameter int NUM_BP = 2,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] insn_addr,
    input  logic              insn_valid,
    input  logic              trace_stored,
    input  logic              wr_en,
    input  logic [1:0]        wr_field,
    input  logic [IDX_W-1:0]  wr_bp,
    input  logic [ADDR_W-1:0] wr_data,
    output logic              trace_freeze,
    output logic              debug_req,
    output logic [NUM_BP-1:0] hit_status
);
    import bkpt_pkg::*;

    wr_field_e         field;
    logic [NUM_BP-1:0] hit_vec;
    logic              clr;
    logic              we_global;

    assign field     = wr_field_e'(wr_field);
    assign we_global = wr_en && (field == FLD_GLOBAL);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        logic sel;
        assign sel = wr_en && (wr_bp == IDX_W'(i));

        bkpt_comparator #(.ADDR_W(ADDR_W)) i_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .bus_addr   (bus_addr),
            .bus_valid  (bus_valid),
            .insn_addr  (insn_addr),
            .insn_valid (insn_valid),
            .we_addr    (sel && (field == FLD_ADDR)),
            .we_mask    (sel && (field == FLD_MASK)),
            .we_ctrl    (sel && (field == FLD_CTRL)),
            .wr_data    (wr_data),
            .clr        (clr),
            .hit        (hit_vec[i]),
            .status     (hit_status[i])
        );
    end

    freeze_sequencer #(.CNT_W(CNT_W), .DATA_W(ADDR_W)) i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_hit      (|hit_vec),
        .trace_stored (trace_stored),
        .we_global    (we_global),
        .wr_data      (wr_data),
        .clr          (clr),
        .trace_freeze (trace_freeze),
        .debug_req    (debug_req)
    );

    // R10: a debug request only accompanies a freeze
    p_debug_with_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        debug_req |-> trace_freeze);

    // R1: nothing is flagged in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> hit_status == '0);

endmodule

// File: tb/test_bkpt_freeze_unit.sv
module test_bkpt_freeze_unit;
    localparam int AW = 8;
    localparam int NB = 2;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] bus_addr, insn_addr, wr_data;
    logic          bus_valid, insn_valid, trace_stored, wr_en;
    logic [1:0]    wr_field;
    logic [0:0]    wr_bp;
    logic          trace_freeze, debug_req;
    logic [NB-1:0] hit_status;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bkpt_freeze_unit #(.ADDR_W(AW), .NUM_BP(NB), .CNT_W(CW)) i_bkpt_freeze_unit (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_valid(bus_valid),
        .insn_addr(insn_addr), .insn_valid(insn_valid),
        .trace_stored(trace_stored),
        .wr_en(wr_en), .wr_field(wr_field), .wr_bp(wr_bp), .wr_data(wr_data),
        .trace_freeze(trace_freeze), .debug_req(debug_req), .hit_status(hit_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] f, input int bp, input logic [AW-1:0] d);
        wr_en = 1'b1; wr_field = f; wr_bp = 1'(bp); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [AW-1:0] gword(input int dly, input bit bof, input bit clr);
        return AW'(dly) | (AW'(bof) << CW) | (AW'(clr) << (CW + 1));
    endfunction

    task automatic glob(input int dly, input bit bof, input bit clr);
        wr(2'd3, 0, gword(dly, bof, clr));
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] masks [5];
        masks = '{8'hFF, 8'hF0, 8'h0F, 8'h00, 8'h81};
        rst_n = 1'b0; bus_addr = '0; insn_addr = '0; wr_data = '0;
        bus_valid = 0; insn_valid = 0; trace_stored = 0; wr_en = 0;
        wr_field = '0; wr_bp = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state; reset regs would match all if enabled
        bus_valid = 1; insn_valid = 1; #5;
        chk("R1 freeze", trace_freeze, 0);
        chk("R1 debug", debug_req, 0);
        tick();
        bus_valid = 0; insn_valid = 0;
        chk("R1 status", hit_status, 0);

        // R2: exhaustive address sweep per mask, delay 0
        wr(2'd0, 0, 8'hA5);
        wr(2'd2, 0, 8'h01);
        foreach (masks[k]) begin
            wr(2'd1, 0, masks[k]);
            for (int a = 0; a < 256; a++) begin
                bus_valid = 1; bus_addr = AW'(a); #5;
                chk("R2 match", trace_freeze, (((AW'(a) ^ 8'hA5) & masks[k]) == 0));
                tick();
                bus_valid = 0;
                glob(0, 0, 1);
            end
        end

        // R11: write applies from next cycle
        wr(2'd1, 0, 8'hFF);
        wr(2'd0, 0, 8'h10);
        wr_en = 1; wr_field = 2'd0; wr_bp = 0; wr_data = 8'h55;
        bus_valid = 1; bus_addr = 8'h55; #5;
        chk("R11 old value used", trace_freeze, 0);
        tick();
        wr_en = 0; #5;
        chk("R11 new value used", trace_freeze, 1);
        tick();
        bus_valid = 0;
        wr(2'd0, 0, 8'h10);
        glob(3, 0, 1);

        // R7/R8: delay of 3, pulse in hit cycle not counted, re-hit mid countdown
        bus_valid = 1; bus_addr = 8'h10; trace_stored = 1; #5;
        chk("R7 hit cycle", trace_freeze, 0);
        tick();
        bus_valid = 0; #5;
        chk("R7 pulse1", trace_freeze, 0);
        tick();
        trace_stored = 0; bus_valid = 1; #5;
        chk("R8 gap with rehit", trace_freeze, 0);
        tick();
        bus_valid = 0; trace_stored = 1; #5;
        chk("R8 pulse2", trace_freeze, 0);
        tick();
        #5;
        chk("R7 pulse3 freezes", trace_freeze, 1);
        chk("R10 no bof", debug_req, 0);
        tick();
        trace_stored = 0;
        for (int c = 0; c < 3; c++) begin
            bus_valid = (c == 1);
            tick();
            chk("R9 freeze held", trace_freeze, 1);
        end
        bus_valid = 0;
        chk("R5 only bp0 flagged", hit_status, 2'b01);

        // R9: clear with a coincident hit
        bus_valid = 1; wr_en = 1; wr_field = 2'd3; wr_data = gword(0, 1, 1);
        tick();
        wr_en = 0; bus_valid = 0;
        chk("R9 freeze cleared", trace_freeze, 0);
        chk("R9 status cleared", hit_status, 0);

        // R6/R10: delay 0 freezes with the hit, debug alongside
        bus_valid = 1; #5;
        chk("R6 same cycle", trace_freeze, 1);
        chk("R10 debug same cycle", debug_req, 1);
        tick();
        bus_valid = 0;
        glob(1, 1, 1);

        // R10: delay 1 with break-on-freeze
        bus_valid = 1; #5;
        chk("R10 pending no debug", debug_req, 0);
        tick();
        bus_valid = 0; trace_stored = 1; #5;
        chk("R7 delay1 freeze", trace_freeze, 1);
        chk("R10 debug on freeze", debug_req, 1);
        tick();
        trace_stored = 0;
        glob(0, 0, 1);

        // R3: bp1 on instruction stream, bp0 disabled
        wr(2'd2, 0, 8'h00);
        wr(2'd0, 1, 8'h3C);
        wr(2'd1, 1, 8'hFF);
        wr(2'd2, 1, 8'h03);
        bus_valid = 1; bus_addr = 8'h3C; #5;
        chk("R3 bus ignored", trace_freeze, 0);
        tick();
        bus_valid = 0;
        chk("R3 no flag from bus", hit_status, 0);
        insn_valid = 1; insn_addr = 8'h3C; #5;
        chk("R3 insn hit", trace_freeze, 1);
        tick();
        insn_valid = 0;
        chk("R5 bp1 flag", hit_status, 2'b10);
        glob(0, 0, 1);

        // R4: disabled bp1
        wr(2'd2, 1, 8'h02);
        insn_valid = 1; #5;
        chk("R4 disabled", trace_freeze, 0);
        tick();
        insn_valid = 0;
        chk("R4 no flag", hit_status, 0);

        // R5: both breakpoints at once
        wr(2'd2, 1, 8'h03);
        wr(2'd0, 1, 8'h20);
        wr(2'd2, 0, 8'h01);
        bus_valid = 1; bus_addr = 8'h10; insn_valid = 1; insn_addr = 8'h20;
        tick();
        bus_valid = 0; insn_valid = 0;
        chk("R5 both flagged", hit_status, 2'b11);
        glob(0, 0, 1);
        chk("R9 both cleared", hit_status, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule